// File: doc/BRIEF.md
# Rounded High-Part Extraction Adder

This block adds or subtracts two 32-bit two's-complement operands and condenses the result into a 16-bit value. Three scaling modes are available. In the first, the sum is shifted down by 12 bits, which is the same as scaling it up by 4 bits and keeping the upper half. In the second, the sum is shifted down by 20 bits and sign-extended. In the third, a single operand is reduced to its rounded upper halfword.

In every mode the block does three things in order. It keeps the full-precision signed sum, one bit wider than the operands. It adds half an LSB at the cut position and truncates. It then clips the value into the signed 16-bit range.

The 16-bit value is written into one half of a destination word. The caller supplies the old destination, and the other half passes through unchanged. Results are registered, so they appear one clock after an accepted request.

Top module: `rxa_round_extract`

## Requirements
- R1: While `rst_n` is low, and until the first accepted request, `out_valid`, `res` and `dst_new` are all zero.
- R2: A request with `in_valid` high gives `out_valid` high on the next clock, together with its `res` and `dst_new`. In a cycle with `in_valid` low, the next `out_valid` is low and `res` and `dst_new` keep their values.
- R3: The sum (`sub_en`=0: op_a+op_b) or difference (`sub_en`=1: op_a−op_b) is formed at 33 bits with no wrap-around before scaling. For example, 0x7FFFFFFF+1 in mode 2'b10 gives 0x0800, and 0x80000000−1 in mode 2'b10 gives 0xF800.
- R4: Mode 2'b01 (scale by 12) returns floor((sum + 2^11) / 2^12), saturated. For example, 0x456789AB+0x6789ABCD gives 0x7FFF, 0x456789AB−0x6789ABCD gives 0x8000, 0x00123456 gives 0x0123, and 0x00123800 gives 0x0124.
- R5: Mode 2'b10 (scale by 20) returns floor((sum + 2^19) / 2^20) as a sign-extended 16-bit value. For example, 0x456789AB+0x6789ABCD gives 0x0ACF, and 0x456789AB−0x6789ABCD gives 0xFDDE.
- R6: Modes 2'b00 and 2'b11 return floor((op_a + 2^15) / 2^16), saturated, and `op_b` and `sub_en` have no effect. For example, 0x6789ABCD gives 0x678A and 0x80000000 gives 0x8000.
- R7: Saturation is applied after rounding. A rounded value above 32767 gives 0x7FFF, and one below −32768 gives 0x8000. For example, 0x07FFF800 in mode 2'b01 gives 0x7FFF, and 0x7FFF8000 in mode 2'b00 gives 0x7FFF.
- R8: With `dst_sel_hi`=1, `dst_new` = {res, dst_old[15:0]}. With `dst_sel_hi`=0, `dst_new` = {dst_old[31:16], res}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request accepted this cycle |
| sub_en | input | 1 | 1 subtracts op_b from op_a, 0 adds them |
| mode | input | 2 | 00/11 single-operand round at 16, 01 scale by 12, 10 scale by 20 |
| op_a | input | 32 | First signed operand |
| op_b | input | 32 | Second signed operand |
| dst_sel_hi | input | 1 | 1 writes the upper half of the destination, 0 the lower |
| dst_old | input | 32 | Current destination word |
| out_valid | output | 1 | Result registers loaded on the previous clock |
| res | output | 16 | Rounded, saturated 16-bit result |
| dst_new | output | 32 | Destination with the selected half replaced |

## Verification
The datapath holds no state between requests, so a wrong internal value shows at `res` and `dst_new` one clock after the request that caused it. A missing sign bit makes wide sums wrap. The scale-by-20 boundary operands expose this as a sign flip of the result. A rounding constant at the wrong bit moves the tie cases by one LSB. Saturation applied before rounding lets 0x8000 escape where 0x7FFF is required. A fault in the output register shows as a changed result during idle cycles or a wrong `out_valid`. A swapped half-select shows as a corrupted passthrough half.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

   typedef enum logic [1:0] {
      RXA_HALF16     = 2'b00,
      RXA_SCALE12    = 2'b01,
      RXA_SCALE20    = 2'b10,
      RXA_HALF16_ALT = 2'b11
   } rxa_mode_e;

   localparam int unsigned RXA_NCUT = 3;

endpackage

// File: rtl/rxa_wide_sum.sv
module rxa_wide_sum #(
   parameter int unsigned DW = 32
) (
   input  logic [DW-1:0]        a,
   input  logic [DW-1:0]        b,
   input  logic                 sub_en,
   input  logic                 single,
   output logic signed [DW:0]   sum
);

   logic signed [DW:0] ea;
   logic signed [DW:0] eb;

   always_comb begin
      ea = {a[DW-1], a};
      eb = {b[DW-1], b};
      if (single)
         sum = ea;
      else if (sub_en)
         sum = ea - eb;
      else
         sum = ea + eb;
   end

endmodule

// File: rtl/rxa_sat_clip.sv
module rxa_sat_clip #(
   parameter int unsigned XW = 34,
   parameter int unsigned RW = 16
) (
   input  logic signed [XW-1:0] v,
   output logic [RW-1:0]        q
);

   localparam int unsigned HW = XW - RW + 1;

   if (RW < 2 || RW >= XW) begin : g_bad_width
      $error("rxa_sat_clip: RW must be at least 2 and below XW");
   end

   logic [HW-1:0] top;
   logic          fits;

   always_comb begin
      top  = v[XW-1:RW-1];
      fits = (top == '0) || (top == '1);
      if (fits)
         q = v[RW-1:0];
      else if (v[XW-1])
         q = {1'b1, {(RW-1){1'b0}}};
      else
         q = {1'b0, {(RW-1){1'b1}}};
   end

endmodule

// File: rtl/rxa_round_cut.sv
module rxa_round_cut #(
   parameter int unsigned IW  = 33,
   parameter int unsigned RW  = 16,
   parameter int unsigned CUT = 12
) (
   input  logic signed [IW-1:0] val,
   output logic [RW-1:0]        res
);

   localparam int unsigned XW   = IW + 1;
   localparam logic [XW-1:0] HALF = XW'(1) << (CUT - 1);

   if (CUT < 1 || CUT >= IW) begin : g_bad_cut
      $error("rxa_round_cut: CUT must lie within the operand width");
   end

   logic signed [XW-1:0] ext;
   logic signed [XW-1:0] rnd;
   logic signed [XW-1:0] shf;

   always_comb begin
      ext = {val[IW-1], val};
      rnd = ext + HALF;
      shf = rnd >>> CUT;
   end

   rxa_sat_clip #(.XW(XW), .RW(RW)) u_clip (
      .v (shf),
      .q (res)
   );

endmodule

// File: rtl/rxa_half_merge.sv
module rxa_half_merge #(
   parameter int unsigned DW = 32,
   parameter int unsigned RW = 16
) (
   input  logic [DW-1:0] dst_old,
   input  logic [RW-1:0] part,
   input  logic          sel_hi,
   output logic [DW-1:0] dst_out
);

   if (DW != 2 * RW) begin : g_bad_split
      $error("rxa_half_merge: destination must be exactly two result halves");
   end

   always_comb begin
      if (sel_hi)
         dst_out = {part, dst_old[RW-1:0]};
      else
         dst_out = {dst_old[DW-1:RW], part};
   end

endmodule

// File: rtl/rxa_round_extract.sv
module rxa_round_extract #(
   parameter int unsigned DW     = 32,
   parameter int unsigned RW     = 16,
   parameter int unsigned CUT_LO = 12,
   parameter int unsigned CUT_HI = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          sub_en,
   input  logic [1:0]    mode,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   input  logic          dst_sel_hi,
   input  logic [DW-1:0] dst_old,
   output logic          out_valid,
   output logic [RW-1:0] res,
   output logic [DW-1:0] dst_new
);

   import rxa_pkg::*;

   localparam int unsigned SW      = DW + 1;
   localparam int unsigned CUT_MID = DW - RW;

   if (CUT_LO < 1 || CUT_HI >= DW || CUT_LO >= CUT_HI) begin : g_bad_cuts
      $error("rxa_round_extract: cut positions out of order or range");
   end

   function automatic int unsigned cut_at(input int unsigned idx);
      case (idx)
         1:       return CUT_LO;
         2:       return CUT_HI;
         default: return CUT_MID;
      endcase
   endfunction

   rxa_mode_e          m;
   logic               single;
   logic signed [SW-1:0] sum;
   logic [RW-1:0]      cand [RXA_NCUT];
   logic [RW-1:0]      pick;
   logic [DW-1:0]      merged;

   assign m      = rxa_mode_e'(mode);
   assign single = (m == RXA_HALF16) || (m == RXA_HALF16_ALT);

   rxa_wide_sum #(.DW(DW)) u_sum (
      .a      (op_a),
      .b      (op_b),
      .sub_en (sub_en),
      .single (single),
      .sum    (sum)
   );

   for (genvar gi = 0; gi < RXA_NCUT; gi++) begin : g_lane
      rxa_round_cut #(.IW(SW), .RW(RW), .CUT(cut_at(gi))) u_cut (
         .val (sum),
         .res (cand[gi])
      );
   end

   always_comb begin
      case (m)
         RXA_SCALE12: pick = cand[1];
         RXA_SCALE20: pick = cand[2];
         default:     pick = cand[0];
      endcase
   end

   rxa_half_merge #(.DW(DW), .RW(RW)) u_merge (
      .dst_old (dst_old),
      .part    (pick),
      .sel_hi  (dst_sel_hi),
      .dst_out (merged)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res       <= '0;
         dst_new   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            res     <= pick;
            dst_new <= merged;
         end
      end
   end

endmodule

// File: rtl/rxa_round_extract_chk.sv
module rxa_round_extract_chk #(
   parameter int unsigned DW = 32,
   parameter int unsigned RW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [1:0]    mode,
   input logic [DW-1:0] op_a,
   input logic          dst_sel_hi,
   input logic [DW-1:0] dst_old,
   input logic          out_valid,
   input logic [RW-1:0] res,
   input logic [DW-1:0] dst_new
);

   AST_ACCEPT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);  // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(res) && $stable(dst_new)));  // R2

   AST_HIGH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst_sel_hi) |=>
         (dst_new[RW-1:0] == $past(dst_old[RW-1:0]) && dst_new[DW-1:RW] == res));  // R8

   AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dst_sel_hi) |=>
         (dst_new[DW-1:RW] == $past(dst_old[DW-1:RW]) && dst_new[RW-1:0] == res));  // R8

   AST_NONNEG_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (mode == 2'b00 || mode == 2'b11) && !op_a[DW-1]) |=> !res[RW-1]);  // R7

endmodule

bind rxa_round_extract rxa_round_extract_chk #(.DW(DW), .RW(RW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .mode       (mode),
   .op_a       (op_a),
   .dst_sel_hi (dst_sel_hi),
   .dst_old    (dst_old),
   .out_valid  (out_valid),
   .res        (res),
   .dst_new    (dst_new)
);

// File: tb/sim_rxa_round_extract.sv
module sim_rxa_round_extract;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        sub_en = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic        dst_sel_hi = 1'b0;
   logic [31:0] dst_old = '0;
   logic        out_valid;
   logic [15:0] res;
   logic [31:0] dst_new;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   rxa_round_extract u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .sub_en     (sub_en),
      .mode       (mode),
      .op_a       (op_a),
      .op_b       (op_b),
      .dst_sel_hi (dst_sel_hi),
      .dst_old    (dst_old),
      .out_valid  (out_valid),
      .res        (res),
      .dst_new    (dst_new)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Issue one request, then sample 2 ns after the capturing edge.
   task automatic issue(input logic s, input logic [1:0] md, input logic [31:0] a,
                        input logic [31:0] b, input logic hi, input logic [31:0] old);
      @(negedge clk);
      in_valid = 1'b1; sub_en = s; mode = md; op_a = a; op_b = b;
      dst_sel_hi = hi; dst_old = old;
      @(posedge clk);
      #2;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 out_valid", {31'd0, out_valid}, 32'd0);
      check("R1 res", {16'd0, res}, 32'd0);
      check("R1 dst_new", dst_new, 32'd0);
   endtask

   task automatic t_scale12();
      issue(1'b0, 2'b01, 32'h456789AB, 32'h6789ABCD, 1'b0, 32'h0);
      check("R4 sum saturates high", {16'd0, res}, 32'h7FFF);
      issue(1'b1, 2'b01, 32'h456789AB, 32'h6789ABCD, 1'b0, 32'h0);
      check("R4 diff saturates low", {16'd0, res}, 32'h8000);
      issue(1'b0, 2'b01, 32'h00123456, 32'h0, 1'b0, 32'h0);
      check("R4 below half", {16'd0, res}, 32'h0123);
      issue(1'b0, 2'b01, 32'h00123800, 32'h0, 1'b0, 32'h0);
      check("R4 tie rounds up", {16'd0, res}, 32'h0124);
      issue(1'b0, 2'b01, 32'hFFFFF800, 32'h0, 1'b0, 32'h0);
      check("R4 negative tie", {16'd0, res}, 32'h0000);
      issue(1'b0, 2'b01, 32'hFFFFF7FF, 32'h0, 1'b0, 32'h0);
      check("R4 negative below tie", {16'd0, res}, 32'hFFFF);
   endtask

   task automatic t_scale20();
      issue(1'b0, 2'b10, 32'h456789AB, 32'h6789ABCD, 1'b0, 32'h0);
      check("R5 positive sum", {16'd0, res}, 32'h0ACF);
      issue(1'b1, 2'b10, 32'h456789AB, 32'h6789ABCD, 1'b0, 32'h0);
      check("R5 negative difference", {16'd0, res}, 32'hFDDE);
   endtask

   task automatic t_wide();
      issue(1'b0, 2'b10, 32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h0);
      check("R3 no wrap on add", {16'd0, res}, 32'h0800);
      issue(1'b1, 2'b10, 32'h80000000, 32'h00000001, 1'b0, 32'h0);
      check("R3 no wrap on subtract", {16'd0, res}, 32'hF800);
   endtask

   task automatic t_single();
      issue(1'b0, 2'b00, 32'h6789ABCD, 32'h0, 1'b0, 32'h0);
      check("R6 upper half rounded", {16'd0, res}, 32'h678A);
      issue(1'b1, 2'b00, 32'h6789ABCD, 32'h7FFFFFFF, 1'b0, 32'h0);
      check("R6 op_b and sub_en ignored", {16'd0, res}, 32'h678A);
      issue(1'b0, 2'b11, 32'h6789ABCD, 32'h12345678, 1'b0, 32'h0);
      check("R6 mode 11 alias", {16'd0, res}, 32'h678A);
      issue(1'b0, 2'b00, 32'h80000000, 32'h0, 1'b0, 32'h0);
      check("R6 most negative", {16'd0, res}, 32'h8000);
   endtask

   task automatic t_sat();
      issue(1'b0, 2'b01, 32'h07FFF800, 32'h0, 1'b0, 32'h0);
      check("R7 rounding overflows scale12", {16'd0, res}, 32'h7FFF);
      issue(1'b0, 2'b00, 32'h7FFF8000, 32'h0, 1'b0, 32'h0);
      check("R7 rounding overflows half16", {16'd0, res}, 32'h7FFF);
   endtask

   task automatic t_merge();
      issue(1'b0, 2'b10, 32'h456789AB, 32'h6789ABCD, 1'b1, 32'h12345678);
      check("R8 upper half written", dst_new, 32'h0ACF5678);
      issue(1'b1, 2'b10, 32'h456789AB, 32'h6789ABCD, 1'b0, 32'h13579BDF);
      check("R8 lower half written", dst_new, 32'h1357FDDE);
   endtask

   task automatic t_hold();
      issue(1'b0, 2'b00, 32'h6789ABCD, 32'h0, 1'b1, 32'hA5A5A5A5);
      check("R2 valid after request", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
      sub_en = 1'b1; mode = 2'b01; op_a = 32'h11111111; dst_old = 32'h0; dst_sel_hi = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk);
         #2;
         check("R2 idle valid low", {31'd0, out_valid}, 32'd0);
         check("R2 idle res held", {16'd0, res}, 32'h678A);
         check("R2 idle dst held", dst_new, 32'h678AA5A5);
      end
   endtask

   initial begin
      #1_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      t_reset();
      t_scale12();
      t_scale20();
      t_wide();
      t_single();
      t_sat();
      t_merge();
      t_hold();
      report();
   end

endmodule